// File: doc/BRIEF.md
# In-Order Load/Store Address Queue

This block tracks the memory instructions of an out-of-order core in a ring of entries that keeps their program order. The decoder writes up to four loads or stores per cycle into the next sequential free entries. Each entry is offered once to the address-calculation unit. After its address returns, the entry is offered to the data cache, and it is offered again for as long as the cache answers that it could not finish. An entry leaves the ring only when its instruction graduates. A store reaches the cache write port only at that moment.

Graduation is allowed by the active list through a single enable. Within the four oldest entries, entries graduate in order while each one has completed. Any number of loads may graduate in one cycle, but only one store. Because of that, the one store that commits in a cycle may sit in any of the four oldest positions, as long as every entry ahead of it graduates in the same cycle. A flush empties the ring at once. The entry count `DEPTH` must be a power of two.

Top module: `lsq_addr_queue`

## Requirements
- R1: While reset is asserted, and after it is released, the ring is empty: `free_cnt` equals DEPTH (16), and `calc_valid`, `cache_valid` and `commit_valid` are all 0.
- R2: An allocation of `alloc_cnt` entries, from 1 to 4, is written at the tail in slot order, wrapping modulo 16. Bit k of `alloc_store` marks the k-th new entry as a store. A request larger than 4, or larger than `free_cnt`, is dropped whole. `free_cnt` reflects an accepted allocation in the cycle after it is requested.
- R3: Every entry is presented on the calc port exactly once. Entries are presented oldest first, one per cycle, and the first entry is presented in the cycle after its allocation.
- R4: An entry becomes eligible for the cache port in the cycle after `calc_done_valid` names it. The oldest eligible entry is presented first, and an entry is not presented again while its access is outstanding.
- R5: A response with `rsp_code` 0 (hit) marks the named outstanding entry complete. Codes 2 and 3 (dependency or resource conflict) make it eligible for the cache port again in the next cycle.
- R6: Response code 1 (miss) parks the entry. It is not presented to the cache until `refill_valid` names it, and it is presented again in the cycle after that.
- R7: When `grad_en` is high, the completed entries at the head of the ring graduate in order, at most four per cycle, and free their slots by the next cycle. An incomplete entry holds back every younger entry.
- R8: A store is offered for the cache write on `commit_valid`/`commit_idx` only in a cycle where `grad_en` is high and it graduates. At most one store commits per cycle. A second completed store in the window waits for the next cycle, and the committing store may be at any of the four oldest positions.
- R9: A completed entry stays in the ring while `grad_en` is low. `free_cnt` does not rise in that cycle.
- R10: `flush` empties the ring on the next edge and resets the ring position, so the next allocation is placed at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty the ring on the next edge |
| alloc_cnt | input | 3 | Number of entries to allocate this cycle |
| alloc_store | input | 4 | Store flag for each new entry, bit k for the k-th |
| free_cnt | output | 5 | Number of unused entries |
| calc_valid | output | 1 | An entry is sent for address calculation |
| calc_idx | output | 4 | Slot sent for address calculation |
| calc_done_valid | input | 1 | Address calculation finished |
| calc_done_idx | input | 4 | Slot whose address is ready |
| cache_valid | output | 1 | An entry is sent to the data cache |
| cache_idx | output | 4 | Slot sent to the data cache |
| rsp_valid | input | 1 | Cache response present |
| rsp_idx | input | 4 | Slot of the cache response |
| rsp_code | input | 2 | 0 hit, 1 miss, 2 dependency, 3 conflict |
| refill_valid | input | 1 | Refill finished |
| refill_idx | input | 4 | Slot whose refill finished |
| grad_en | input | 1 | Active list permits graduation |
| commit_valid | output | 1 | A store graduates and may write the cache |
| commit_idx | output | 4 | Slot of the committing store |

## Verification
The calc and cache ports, and the commit port, are combinational from registered state and current inputs, so each is read in the same cycle that state allows it. `free_cnt` and cache eligibility change one edge after the allocation, response, refill or graduation that causes them. The bench drives every input just after a rising edge, waits a small delay before reading, and so samples each result exactly one edge after its cause (or in the same cycle for `commit_valid`). It counts ring slots itself, including the wrap through slot 0, to form the expected indices.

// File: rtl/lsq_pkg.sv
package lsq_pkg;

  typedef enum logic [1:0] {
    RSP_HIT   = 2'd0,
    RSP_MISS  = 2'd1,
    RSP_DEP   = 2'd2,
    RSP_BUSY  = 2'd3
  } rsp_e;

  // Slot that lies off positions after base in a ring of depth slots.
  function automatic int ring_slot(int base, int off, int depth);
    return (base + off) % depth;
  endfunction

endpackage

// File: rtl/lsq_pick.sv
module lsq_pick
  import lsq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IW-1:0]    head,
  input  logic [DEPTH-1:0] mask,
  output logic             found,
  output logic [IW-1:0]    idx
);

  // Oldest set bit of mask, counting from head around the ring.
  always_comb begin
    int s;
    found = 1'b0;
    idx   = head;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      s = ring_slot(int'(head), k, DEPTH);
      if (mask[s]) begin
        found = 1'b1;
        idx   = IW'(s);
      end
    end
  end

  assert_pick_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> mask[idx]);

  assert_pick_none_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !found |-> (mask == '0));

endmodule

// File: rtl/lsq_grad.sv
module lsq_grad
  import lsq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIN = 4,
  localparam int IW = $clog2(DEPTH),
  localparam int GW = $clog2(WIN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IW-1:0]    head,
  input  logic [DEPTH-1:0] valid,
  input  logic [DEPTH-1:0] done,
  input  logic [DEPTH-1:0] is_store,
  input  logic             grad_en,
  output logic [DEPTH-1:0] grad_vec,
  output logic [GW-1:0]    grad_n,
  output logic             commit_valid,
  output logic [IW-1:0]    commit_idx
);

  logic [DEPTH-1:0] store_go;

  // In-order scan of the oldest WIN slots; the first blocked slot stops it.
  always_comb begin
    int  s;
    logic go;
    logic st_used;
    go           = grad_en;
    st_used      = 1'b0;
    grad_vec     = '0;
    store_go     = '0;
    grad_n       = '0;
    commit_valid = 1'b0;
    commit_idx   = head;
    for (int k = 0; k < WIN; k++) begin
      s = ring_slot(int'(head), k, DEPTH);
      if (go && valid[s] && done[s] && !(is_store[s] && st_used)) begin
        grad_vec[s] = 1'b1;
        grad_n      = grad_n + GW'(1);
        if (is_store[s]) begin
          st_used      = 1'b1;
          store_go[s]  = 1'b1;
          commit_valid = 1'b1;
          commit_idx   = IW'(s);
        end
      end else begin
        go = 1'b0;
      end
    end
  end

  assert_single_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(store_go) <= 1);

  assert_commit_complete_R8: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |-> (is_store[commit_idx] && done[commit_idx] && valid[commit_idx]));

  assert_grad_only_enabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !grad_en |-> (grad_vec == '0));

endmodule

// File: rtl/lsq_addr_queue.sv
module lsq_addr_queue
  import lsq_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int ALLOC_W = 4,
  parameter int WIN     = 4,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1),
  localparam int AW = $clog2(ALLOC_W + 1),
  localparam int GW = $clog2(WIN + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic [AW-1:0]      alloc_cnt,
  input  logic [ALLOC_W-1:0] alloc_store,
  output logic [CW-1:0]      free_cnt,
  output logic               calc_valid,
  output logic [IW-1:0]      calc_idx,
  input  logic               calc_done_valid,
  input  logic [IW-1:0]      calc_done_idx,
  output logic               cache_valid,
  output logic [IW-1:0]      cache_idx,
  input  logic               rsp_valid,
  input  logic [IW-1:0]      rsp_idx,
  input  logic [1:0]         rsp_code,
  input  logic               refill_valid,
  input  logic [IW-1:0]      refill_idx,
  input  logic               grad_en,
  output logic               commit_valid,
  output logic [IW-1:0]      commit_idx
);

  // Ring position and per-entry state.
  logic [IW-1:0]    head_q;
  logic [CW-1:0]    cnt_q;
  logic [DEPTH-1:0] valid_q, store_q, sent_q, addr_q, inflt_q, park_q, done_q;

  function automatic logic alloc_ok(logic [AW-1:0] n, logic [CW-1:0] room);
    return (n != '0) && (int'(n) <= ALLOC_W) && (int'(n) <= int'(room));
  endfunction

  logic [IW-1:0] tail;
  assign tail     = head_q + IW'(cnt_q);
  assign free_cnt = CW'(DEPTH) - cnt_q;

  // Named internal events.
  logic             alloc_fire;
  logic [DEPTH-1:0] alloc_vec, alloc_st_vec;
  logic [DEPTH-1:0] calc_issue_vec, addr_ret_vec, cache_issue_vec;
  logic [DEPTH-1:0] rsp_vec, refill_vec;
  logic [DEPTH-1:0] grad_vec;
  logic [GW-1:0]    grad_n;
  rsp_e             code;

  assign alloc_fire = alloc_ok(alloc_cnt, free_cnt);
  assign code       = rsp_e'(rsp_code);

  always_comb begin
    int s;
    alloc_vec    = '0;
    alloc_st_vec = '0;
    for (int k = 0; k < ALLOC_W; k++) begin
      s = ring_slot(int'(tail), k, DEPTH);
      if (alloc_fire && (k < int'(alloc_cnt))) begin
        alloc_vec[s]    = 1'b1;
        alloc_st_vec[s] = alloc_store[k];
      end
    end
  end

  logic [DEPTH-1:0] calc_mask, cache_mask;
  assign calc_mask  = valid_q & ~sent_q;
  assign cache_mask = valid_q & addr_q & ~inflt_q & ~park_q & ~done_q;

  lsq_pick #(.DEPTH(DEPTH)) u_calc_pick (
    .clk(clk), .rst_n(rst_n), .head(head_q), .mask(calc_mask),
    .found(calc_valid), .idx(calc_idx)
  );

  lsq_pick #(.DEPTH(DEPTH)) u_cache_pick (
    .clk(clk), .rst_n(rst_n), .head(head_q), .mask(cache_mask),
    .found(cache_valid), .idx(cache_idx)
  );

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_ev
      assign calc_issue_vec[g]  = calc_valid && (calc_idx == IW'(g));
      assign cache_issue_vec[g] = cache_valid && (cache_idx == IW'(g));
      assign addr_ret_vec[g]    = calc_done_valid && (calc_done_idx == IW'(g)) &&
                                  valid_q[g] && sent_q[g] && !addr_q[g];
      assign rsp_vec[g]         = rsp_valid && (rsp_idx == IW'(g)) && inflt_q[g];
      assign refill_vec[g]      = refill_valid && (refill_idx == IW'(g)) && park_q[g];
    end
  endgenerate

  lsq_grad #(.DEPTH(DEPTH), .WIN(WIN)) u_grad (
    .clk(clk), .rst_n(rst_n), .head(head_q), .valid(valid_q), .done(done_q),
    .is_store(store_q), .grad_en(grad_en), .grad_vec(grad_vec), .grad_n(grad_n),
    .commit_valid(commit_valid), .commit_idx(commit_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      head_q  <= '0;
      cnt_q   <= '0;
      valid_q <= '0;
      store_q <= '0;
      sent_q  <= '0;
      addr_q  <= '0;
      inflt_q <= '0;
      park_q  <= '0;
      done_q  <= '0;
    end else begin
      head_q <= head_q + IW'(grad_n);
      cnt_q  <= cnt_q - CW'(grad_n) + (alloc_fire ? CW'(alloc_cnt) : CW'(0));
      for (int i = 0; i < DEPTH; i++) begin
        if (alloc_vec[i]) begin
          valid_q[i] <= 1'b1;
          store_q[i] <= alloc_st_vec[i];
          sent_q[i]  <= 1'b0;
          addr_q[i]  <= 1'b0;
          inflt_q[i] <= 1'b0;
          park_q[i]  <= 1'b0;
          done_q[i]  <= 1'b0;
        end else begin
          if (calc_issue_vec[i])  sent_q[i]  <= 1'b1;
          if (addr_ret_vec[i])    addr_q[i]  <= 1'b1;
          if (cache_issue_vec[i]) inflt_q[i] <= 1'b1;
          if (rsp_vec[i]) begin
            inflt_q[i] <= 1'b0;
            case (code)
              RSP_HIT:  done_q[i] <= 1'b1;
              RSP_MISS: park_q[i] <= 1'b1;
              default:  ;
            endcase
          end
          if (refill_vec[i]) park_q[i] <= 1'b0;
          if (grad_vec[i]) begin
            valid_q[i] <= 1'b0;
            store_q[i] <= 1'b0;
            sent_q[i]  <= 1'b0;
            addr_q[i]  <= 1'b0;
            inflt_q[i] <= 1'b0;
            park_q[i]  <= 1'b0;
            done_q[i]  <= 1'b0;
          end
        end
      end
    end
  end

  assert_count_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q == CW'($countones(valid_q)));

  assert_calc_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
    calc_valid |=> !(calc_valid && (calc_idx == $past(calc_idx))));

  assert_no_reissue_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cache_valid && !flush) |=> !(cache_valid && (cache_idx == $past(cache_idx))));

  assert_miss_parks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && inflt_q[rsp_idx] && (rsp_code == 2'd1) && !flush)
      |=> !(cache_valid && (cache_idx == $past(rsp_idx))));

  assert_commit_needs_grad_R8: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |-> grad_en);

  assert_hold_without_grad_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!grad_en && !flush) |=> (cnt_q >= $past(cnt_q)));

  assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> ((free_cnt == CW'(DEPTH)) && !calc_valid && !cache_valid));

endmodule

// File: tb/tb_lsq_addr_queue.sv
module tb_lsq_addr_queue;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n, flush;
  logic [2:0] alloc_cnt;
  logic [3:0] alloc_store;
  logic [4:0] free_cnt;
  logic       calc_valid, calc_done_valid, cache_valid, rsp_valid, refill_valid;
  logic [3:0] calc_idx, calc_done_idx, cache_idx, rsp_idx, refill_idx, commit_idx;
  logic [1:0] rsp_code;
  logic       grad_en, commit_valid;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  lsq_addr_queue dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .alloc_cnt(alloc_cnt),
    .alloc_store(alloc_store), .free_cnt(free_cnt), .calc_valid(calc_valid),
    .calc_idx(calc_idx), .calc_done_valid(calc_done_valid),
    .calc_done_idx(calc_done_idx), .cache_valid(cache_valid), .cache_idx(cache_idx),
    .rsp_valid(rsp_valid), .rsp_idx(rsp_idx), .rsp_code(rsp_code),
    .refill_valid(refill_valid), .refill_idx(refill_idx), .grad_en(grad_en),
    .commit_valid(commit_valid), .commit_idx(commit_idx)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Advance one edge, then clear every pulse input.
  task automatic cyc();
    @(posedge clk);
    #1;
    flush = 0; alloc_cnt = 0; alloc_store = 0; calc_done_valid = 0;
    rsp_valid = 0; refill_valid = 0; grad_en = 0; rsp_code = 0;
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic do_alloc(input int n, input logic [3:0] st);
    alloc_cnt = 3'(n); alloc_store = st; cyc();
  endtask

  // Address return, then cache issue, then hit.
  task automatic finish_entry(input int idx);
    calc_done_valid = 1; calc_done_idx = 4'(idx); cyc();
    settle();
    chk("R4 cache_valid", int'(cache_valid), 1);
    chk("R4 cache_idx", int'(cache_idx), idx);
    cyc();
    rsp_valid = 1; rsp_idx = 4'(idx); rsp_code = 2'd0; cyc();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; flush = 0; alloc_cnt = 0; alloc_store = 0; calc_done_valid = 0;
    calc_done_idx = 0; rsp_valid = 0; rsp_idx = 0; rsp_code = 0; refill_valid = 0;
    refill_idx = 0; grad_en = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    grad_en = 1; settle();
    chk("R1 free", int'(free_cnt), 16);
    chk("R1 calc_valid", int'(calc_valid), 0);
    chk("R1 cache_valid", int'(cache_valid), 0);
    chk("R1 commit_valid", int'(commit_valid), 0);
    cyc();

    // Three entries, slot 1 a store.
    do_alloc(3, 4'b0010);
    settle();
    chk("R2 free after alloc", int'(free_cnt), 13);
    chk("R3 calc first", int'(calc_idx), 0);
    cyc(); settle(); chk("R3 calc second", int'(calc_idx), 1);
    cyc(); settle(); chk("R3 calc third", int'(calc_idx), 2);
    cyc(); settle(); chk("R3 calc once", int'(calc_valid), 0);
    chk("R4 no addr no cache", int'(cache_valid), 0);

    calc_done_valid = 1; calc_done_idx = 2; cyc(); settle();
    chk("R4 cache after addr", int'(cache_idx), 2);
    chk("R4 cache valid", int'(cache_valid), 1);
    calc_done_valid = 1; calc_done_idx = 0; cyc(); settle();
    chk("R4 oldest eligible", int'(cache_idx), 0);
    cyc(); settle();
    chk("R4 no reissue while outstanding", int'(cache_valid), 0);

    rsp_valid = 1; rsp_idx = 0; rsp_code = 2'd2; cyc(); settle();
    chk("R5 retry reissued", int'(cache_valid), 1);
    chk("R5 retry idx", int'(cache_idx), 0);
    cyc();
    rsp_valid = 1; rsp_idx = 0; rsp_code = 2'd1; cyc(); settle();
    chk("R6 miss parks", int'(cache_valid), 0);
    cyc(); settle();
    chk("R6 still parked", int'(cache_valid), 0);
    rsp_valid = 1; rsp_idx = 2; rsp_code = 2'd0; cyc();
    refill_valid = 1; refill_idx = 0; cyc(); settle();
    chk("R6 refill reissue", int'(cache_valid), 1);
    chk("R6 refill idx", int'(cache_idx), 0);
    cyc();
    rsp_valid = 1; rsp_idx = 0; rsp_code = 2'd0; cyc();

    settle();
    chk("R9 done entries stay", int'(free_cnt), 13);
    chk("R8 no commit without grad", int'(commit_valid), 0);
    grad_en = 1; settle();
    chk("R8 incomplete store no commit", int'(commit_valid), 0);
    cyc(); settle();
    chk("R7 head load graduates", int'(free_cnt), 14);
    grad_en = 1; cyc(); settle();
    chk("R7 blocked by incomplete store", int'(free_cnt), 14);

    finish_entry(1);
    settle();
    chk("R8 done store waits for grad", int'(commit_valid), 0);
    grad_en = 1; settle();
    chk("R8 commit valid", int'(commit_valid), 1);
    chk("R8 commit idx", int'(commit_idx), 1);
    cyc(); settle();
    chk("R7 store and load graduate", int'(free_cnt), 16);

    // Two stores in the window: slots 3..6, stores at 4 and 5.
    do_alloc(4, 4'b0110);
    repeat (4) cyc();
    for (int e = 3; e <= 6; e++) finish_entry(e);
    grad_en = 1; settle();
    chk("R8 first store commits", int'(commit_idx), 4);
    cyc(); settle();
    chk("R8 one store per cycle", int'(free_cnt), 14);
    grad_en = 1; settle();
    chk("R8 second store next cycle", int'(commit_idx), 5);
    cyc(); settle();
    chk("R7 window drained", int'(free_cnt), 16);

    // Store at the fourth oldest position: slots 7..10, store at 10.
    do_alloc(4, 4'b1000);
    repeat (4) cyc();
    for (int e = 7; e <= 10; e++) finish_entry(e);
    grad_en = 1; settle();
    chk("R8 store at position 3", int'(commit_valid), 1);
    chk("R8 store at position 3 idx", int'(commit_idx), 10);
    cyc(); settle();
    chk("R7 four graduate", int'(free_cnt), 16);

    // Oversize request, then fill to full with wrap.
    do_alloc(5, 4'b0000); settle();
    chk("R2 oversize dropped", int'(free_cnt), 16);
    chk("R2 oversize no calc", int'(calc_valid), 0);
    do_alloc(4, 4'b0000); settle();
    chk("R3 calc from tail", int'(calc_idx), 11);
    chk("R2 free 12", int'(free_cnt), 12);
    do_alloc(4, 4'b0000); settle();
    chk("R3 calc wrap k1", int'(calc_idx), 12);
    do_alloc(4, 4'b0000); settle();
    chk("R3 calc wrap k2", int'(calc_idx), 13);
    do_alloc(4, 4'b0000); settle();
    chk("R3 calc wrap k3", int'(calc_idx), 14);
    chk("R2 full", int'(free_cnt), 0);
    do_alloc(1, 4'b0000); settle();
    chk("R2 no room dropped", int'(free_cnt), 0);
    chk("R3 calc wrap k4", int'(calc_idx), 15);
    for (int k = 5; k < 16; k++) begin
      cyc(); settle();
      chk("R3 calc wrap order", int'(calc_idx), (11 + k) % 16);
    end
    cyc(); settle();
    chk("R3 all sent once", int'(calc_valid), 0);

    flush = 1; cyc(); settle();
    chk("R10 flush free", int'(free_cnt), 16);
    chk("R10 flush calc", int'(calc_valid), 0);
    chk("R10 flush cache", int'(cache_valid), 0);
    do_alloc(1, 4'b0000); settle();
    chk("R10 position reset", int'(calc_idx), 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule